// File: doc/BRIEF.md
# Sensing Time-Constant Calibration Controller

This controller trims a digitally switched resistor in a lossless capacitor-current sensing branch. The goal is to make the branch's RC time constant equal to that of the output capacitor bank. Trimming happens while the regulator's reference is being ramped. During the ramp almost all of the inductor current charges the output capacitors, so a filtered copy of the inductor current can serve as the reference for the true capacitor current. An external window comparator weighs the filtered sensing-branch signal against that reference. It reports whether the sensing signal is the larger of the two, and whether the two lie within its hysteresis band.

Calibration starts on each rising edge of the voltage-scaling indication. The controller then pulses the comparator enable once per comparison interval. The default interval is 4375 cycles, which is 35 µs at 125 MHz. At the last cycle of each pulse it reads the synchronized comparator result and moves the resistor code down one step, moves it up one step, or freezes it. Code k selects a resistance of 100 Ω + 40 Ω·k, so the default four codes cover 100 Ω to 220 Ω. Calibration has to settle before power-good arrives. If power-good comes first, the current code is kept and the result is marked incomplete.

Top module: `tc_cal_ctrl`

## Requirements
- R1: After reset, res_code_o equals CODE_INIT and cmp_en_o, cal_done_o, cal_incomplete_o and code_limit_o are all 0.
- R2: A rising edge on scale_active_i, seen while calibration is not running, starts calibration and clears cal_done_o, cal_incomplete_o and code_limit_o. The edge is seen at the clock edge where scale_active_i is first high. From that clock edge, cmp_en_o first goes high INTERVAL_CYC-EN_CYC+1 cycles later. It stays high for exactly EN_CYC cycles, and its rising edges repeat every INTERVAL_CYC cycles.
- R3: Consider the clock edge that ends an enable pulse. If at that edge sense_above_i=1 and in_window_i=0, res_code_o decreases by 1.
- R4: If at the clock edge that ends an enable pulse sense_above_i=0 and in_window_i=0, res_code_o increases by 1.
- R5: If at the clock edge that ends an enable pulse in_window_i=1, res_code_o is held, cal_done_o becomes 1, cal_incomplete_o stays 0, and no further enable pulses are issued.
- R6: res_code_o never goes below CODE_MIN or above CODE_MAX. A step request at either limit leaves the code unchanged and sets code_limit_o, which stays set until the next start.
- R7: If power_good_i is high while calibration runs, cal_done_o and cal_incomplete_o become 1 at the next clock edge, res_code_o is frozen, and no further enable pulses are issued.
- R8: If scale_active_i goes low while calibration runs, enable pulses stop, res_code_o is held and cal_done_o stays 0 until the next start.
- R9: Comparator inputs have no effect on res_code_o outside the enable pulse's sampling edge, including after calibration is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scale_active_i | input | 1 | Reference ramp in progress |
| power_good_i | input | 1 | Output has reached regulation |
| sense_above_i | input | 1 | Filtered sensing signal above filtered reference |
| in_window_i | input | 1 | Difference within comparator hysteresis |
| cmp_en_o | output | 1 | Comparator enable pulse |
| res_code_o | output | CODE_W | Trim resistor code |
| cal_done_o | output | 1 | Calibration finished (matched or cut short) |
| cal_incomplete_o | output | 1 | Finished by power-good before a window hit |
| code_limit_o | output | 1 | A step was requested at a code limit |

## Verification
The assertions rely on a few properties of the inputs. The scale and power-good inputs are already synchronous to the clock. The comparator outputs are held steady for at least two cycles before the end of each enable pulse, so the sampled value is the one the comparator settled to. The bench sets new comparator levels at the negative edge right after a pulse ends and leaves them unchanged until the next pulse has ended. It only toggles them freely in phases where the controller is idle or done. Random sequences of above, below and window outcomes are drawn from a fixed seed. They are mixed with directed runs into both code limits, a power-good cut-off and a ramp that is dropped mid-calibration.

// File: rtl/tc_cal_pkg.sv
package tc_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/tc_cal_sync.sv
module tc_cal_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tc_cal_timer.sv
module tc_cal_timer #(
  parameter int INTERVAL_CYC = 4375,
  parameter int EN_CYC       = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic en_o,
  output logic sample_o
);
  localparam int CNT_W = $clog2(INTERVAL_CYC);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(INTERVAL_CYC - 1);
  localparam logic [CNT_W-1:0] EN_START_C = CNT_W'(INTERVAL_CYC - EN_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign en_o     = run_i && (cnt_q >= EN_START_C);
  assign sample_o = run_i && (cnt_q == LAST_C);

  // sampling edge always closes an enable pulse
  p_sample_in_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> en_o);
  p_pulse_ends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !en_o);
endmodule

// File: rtl/tc_cal_fsm.sv
module tc_cal_fsm
  import tc_cal_pkg::*;
#(
  parameter int CODE_W    = 2,
  parameter int CODE_MIN  = 0,
  parameter int CODE_MAX  = 3,
  parameter int CODE_INIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scale_i,
  input  logic              pg_i,
  input  logic              sample_i,
  input  logic              above_i,
  input  logic              win_i,
  output logic              run_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              inc_o,
  output logic              limit_o
);
  localparam logic [CODE_W-1:0] MIN_C  = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] MAX_C  = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] INIT_C = CODE_W'(CODE_INIT);

  cal_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic              done_q, inc_q, limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= INIT_C;
      done_q  <= 1'b0;
      inc_q   <= 1'b0;
      limit_q <= 1'b0;
    end else if (start_i && state_q != ST_RUN) begin
      state_q <= ST_RUN;
      done_q  <= 1'b0;
      inc_q   <= 1'b0;
      limit_q <= 1'b0;
    end else if (state_q == ST_RUN) begin
      if (!scale_i) begin
        state_q <= ST_IDLE;
      end else if (pg_i) begin
        state_q <= ST_DONE;
        done_q  <= 1'b1;
        inc_q   <= 1'b1;
      end else if (sample_i) begin
        if (win_i) begin
          state_q <= ST_DONE;
          done_q  <= 1'b1;
        end else if (above_i) begin
          if (code_q == MIN_C) limit_q <= 1'b1;
          else code_q <= code_q - 1'b1;
        end else begin
          if (code_q == MAX_C) limit_q <= 1'b1;
          else code_q <= code_q + 1'b1;
        end
      end
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign code_o  = code_q;
  assign done_o  = done_q;
  assign inc_o   = inc_q;
  assign limit_o = limit_q;

  logic trim_ok;
  assign trim_ok = sample_i && run_o && scale_i && !pg_i && !win_i;

  p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_ok && above_i && code_q != MIN_C) |=> code_q == $past(code_q) - 1'b1);
  p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_ok && !above_i && code_q != MAX_C) |=> code_q == $past(code_q) + 1'b1);
  p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> $stable(code_q) && done_q);
  p_bounds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q >= MIN_C) && (code_q <= MAX_C));
  p_pg_cut_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && scale_i && pg_i) |=> done_q && inc_q && $stable(code_q));
  p_pause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !scale_i) |=> !run_o && !done_q && $stable(code_q));
endmodule

// File: rtl/tc_cal_ctrl.sv
module tc_cal_ctrl #(
  parameter int INTERVAL_CYC = 4375,
  parameter int EN_CYC       = 4,
  parameter int CODE_W       = 2,
  parameter int CODE_MIN     = 0,
  parameter int CODE_MAX     = 3,
  parameter int CODE_INIT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scale_active_i,
  input  logic              power_good_i,
  input  logic              sense_above_i,
  input  logic              in_window_i,
  output logic              cmp_en_o,
  output logic [CODE_W-1:0] res_code_o,
  output logic              cal_done_o,
  output logic              cal_incomplete_o,
  output logic              code_limit_o
);
  logic       scale_d_q, start, run, sample;
  logic [1:0] cmp_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scale_d_q <= 1'b0;
    else scale_d_q <= scale_active_i;
  end

  assign start = scale_active_i && !scale_d_q;

  tc_cal_sync #(.W(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sense_above_i, in_window_i}),
    .q_o    (cmp_sync)
  );

  tc_cal_timer #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .EN_CYC       (EN_CYC)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .en_o     (cmp_en_o),
    .sample_o (sample)
  );

  tc_cal_fsm #(
    .CODE_W    (CODE_W),
    .CODE_MIN  (CODE_MIN),
    .CODE_MAX  (CODE_MAX),
    .CODE_INIT (CODE_INIT)
  ) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .scale_i  (scale_active_i),
    .pg_i     (power_good_i),
    .sample_i (sample),
    .above_i  (cmp_sync[1]),
    .win_i    (cmp_sync[0]),
    .run_o    (run),
    .code_o   (res_code_o),
    .done_o   (cal_done_o),
    .inc_o    (cal_incomplete_o),
    .limit_o  (code_limit_o)
  );

  p_no_en_when_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> !cmp_en_o);
  p_no_en_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scale_active_i && !scale_d_q) |-> !cmp_en_o);
endmodule

// File: tb/test_tc_cal_ctrl.sv
module test_tc_cal_ctrl;
  localparam int INTERVAL = 20;
  localparam int ENC      = 4;
  localparam int CW       = 4;
  localparam int CMIN     = 1;
  localparam int CMAX     = 9;
  localparam int CINIT    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scale = 1'b0, pg = 1'b0, above = 1'b0, win = 1'b0;
  logic en, done, inc, lim;
  logic [CW-1:0] code;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_code = CINIT;
  bit m_done = 0, m_inc = 0, m_lim = 0;
  int last_rise = 0;
  bit have_prev = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
    end
  end

  tc_cal_ctrl #(
    .INTERVAL_CYC (INTERVAL), .EN_CYC (ENC), .CODE_W (CW),
    .CODE_MIN (CMIN), .CODE_MAX (CMAX), .CODE_INIT (CINIT)
  ) i_tc_cal_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .scale_active_i (scale), .power_good_i (pg),
    .sense_above_i (above), .in_window_i (win), .cmp_en_o (en), .res_code_o (code),
    .cal_done_o (done), .cal_incomplete_o (inc), .code_limit_o (lim)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(int'(code) == m_code, {tag, " code"}, int'(code), m_code);
    chk(done == m_done, {tag, " done"}, int'(done), int'(m_done));
    chk(inc == m_inc, {tag, " incomplete"}, int'(inc), int'(m_inc));
    chk(lim == m_lim, {tag, " limit"}, int'(lim), int'(m_lim));
  endtask

  function automatic void model_step(input bit a, input bit w);
    if (w) m_done = 1;
    else if (a) begin
      if (m_code == CMIN) m_lim = 1; else m_code--;
    end else begin
      if (m_code == CMAX) m_lim = 1; else m_code++;
    end
  endfunction

  // en is high at this negedge: measure width, then check the result
  task automatic finish_cmp(input bit a, input bit w, input string tag);
    int width = 0;
    if (have_prev) chk(cyc - last_rise == INTERVAL, "R2 period", cyc - last_rise, INTERVAL);
    last_rise = cyc;
    have_prev = 1;
    while (en && width < 2 * INTERVAL) begin
      width++;
      @(negedge clk);
    end
    chk(width == ENC, "R2 pulse width", width, ENC);
    model_step(a, w);
    chk_state(tag);
    if (m_done) have_prev = 0;
  endtask

  task automatic run_cmp(input bit a, input bit w, input string tag);
    int wait_n = 0;
    above = a;
    win = w;
    while (!en && wait_n < 2 * INTERVAL) begin
      wait_n++;
      @(negedge clk);
    end
    chk(en == 1'b1, "R2 pulse present", int'(en), 1);
    finish_cmp(a, w, tag);
  endtask

  // drop then raise the ramp; checks start latency and flag clearing
  task automatic restart(input bit a, input bit w);
    int n = 0;
    above = a;
    win = w;
    scale = 1'b0;
    @(negedge clk);
    scale = 1'b1;
    have_prev = 0;
    m_done = 0; m_inc = 0; m_lim = 0;
    @(negedge clk);
    n = 1;
    chk_state("R2 start clears flags");
    while (!en && n < 2 * INTERVAL) begin
      n++;
      @(negedge clk);
    end
    chk(n == INTERVAL - ENC + 1, "R2 first pulse latency", n, INTERVAL - ENC + 1);
    finish_cmp(a, w, "R2 first compare");
  endtask

  initial begin
    int seed_dummy;
    bit ok_en;
    int hold_code;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(code) == CINIT, "R1 code", int'(code), CINIT);
    chk(!en && !done && !inc && !lim, "R1 outputs low",
        int'({en, done, inc, lim}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    restart(1'b1, 1'b0);
    run_cmp(1'b1, 1'b0, "R3 step down");
    run_cmp(1'b0, 1'b0, "R4 step up");
    run_cmp(1'b0, 1'b0, "R4 step up again");
    // R6 floor
    while (m_code > CMIN) run_cmp(1'b1, 1'b0, "R3 descend");
    run_cmp(1'b1, 1'b0, "R6 floor hold");
    chk(lim == 1'b1, "R6 limit at floor", int'(lim), 1);
    // R6 ceiling
    while (m_code < CMAX) run_cmp(1'b0, 1'b0, "R4 ascend");
    run_cmp(1'b0, 1'b0, "R6 ceiling hold");
    chk(int'(code) == CMAX, "R6 ceiling code", int'(code), CMAX);
    // R5 window hit
    run_cmp(1'b1, 1'b1, "R5 window freeze");
    // R9 comparator ignored after done
    ok_en = 1;
    hold_code = int'(code);
    for (int i = 0; i < 3 * INTERVAL; i++) begin
      above = 1'($urandom);
      win = 1'($urandom);
      @(negedge clk);
      if (en) ok_en = 0;
    end
    chk(ok_en, "R9 no pulse after done", int'(!ok_en), 0);
    chk(int'(code) == hold_code, "R9 code unaffected", int'(code), hold_code);
    chk(done == 1'b1, "R5 done held", int'(done), 1);

    // R6 limit flag cleared by a new start
    restart(1'b0, 1'b0);

    // random trims
    for (int k = 0; k < 60; k++) begin
      bit a, w;
      a = 1'($urandom);
      w = ($urandom % 8) == 0;
      if (m_done) restart(a, w);
      else run_cmp(a, w, a ? "R3 random" : "R4 random");
      if (w) chk(done == 1'b1, "R5 random window", int'(done), 1);
    end
    if (m_done) restart(1'b1, 1'b0);

    // R8 ramp dropped mid-run
    repeat (3) @(negedge clk);
    scale = 1'b0;
    ok_en = 1;
    hold_code = int'(code);
    for (int i = 0; i < 3 * INTERVAL; i++) begin
      above = 1'($urandom);
      win = 1'($urandom);
      @(negedge clk);
      if (en) ok_en = 0;
    end
    chk(ok_en, "R8 no pulse while paused", int'(!ok_en), 0);
    chk(int'(code) == hold_code, "R8 code held", int'(code), hold_code);
    chk(done == 1'b0, "R8 not done", int'(done), 0);
    have_prev = 0;
    restart(1'b0, 1'b0);

    // R7 power-good cuts calibration short
    repeat (2) @(negedge clk);
    pg = 1'b1;
    @(negedge clk);
    m_done = 1;
    m_inc = 1;
    chk_state("R7 power-good cut");
    ok_en = 1;
    hold_code = int'(code);
    for (int i = 0; i < 2 * INTERVAL; i++) begin
      above = 1'($urandom);
      win = 1'b0;
      @(negedge clk);
      if (en) ok_en = 0;
    end
    chk(ok_en, "R7 no pulse after cut", int'(!ok_en), 0);
    chk(int'(code) == hold_code, "R9 code unaffected after cut", int'(code), hold_code);
    pg = 1'b0;
    restart(1'b1, 1'b0);
    chk(inc == 1'b0, "R2 incomplete cleared", int'(inc), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule